// File: doc/BRIEF.md
# Keyed-Write Memory Refresh Interval Timer

This block paces refresh cycles for a dynamic memory. A free-running prescaler feeds an 8-bit interval counter at a rate picked by a 3-bit clock-select field. The count runs up to a compare value. When the count reaches that value, the compare-match flag is raised. On the next count step the counter returns to zero and a one-cycle refresh request is issued, provided refresh is enabled and the refresh mode is CBR rather than self-refresh. A second counter tallies the refresh requests. When that tally reaches a selectable limit it raises an overflow flag, and each flag can drive its own interrupt.

Software reaches three 16-bit registers over a small bus: control/status at address 0, interval counter at address 1 and compare value at address 2. A write lands only when it is a full word and its upper byte holds a fixed key. This guards the registers against stray stores. The flags cannot be set by software. Writing 0 to a flag that reads 1 arms a clear, and the next refresh request that is actually issued removes the flag.

Top module: `refresh_interval_timer`

## Requirements
- R1: After power-on reset, all three registers read 0x0000 and `refresh_req`, `irq_match` and `irq_ovf` are 0.
- R2: A register changes only on a write with `bus_wr`=1, `bus_word`=1 and `bus_wdata[15:8]`=0xA5; any other write, including a keyed write with `bus_word`=0, leaves the register unchanged.
- R3: The control/status register reads as {8'h00, match flag, match-irq enable, clock select[2:0], overflow flag, overflow-irq enable, limit select}, from bit 15 down to bit 0, and a keyed write loads bits 6, 5:3, 1 and 0 from `bus_wdata`.
- R4: Writing 1 to either flag bit (7 or 2) never changes that flag.
- R5: Clock-select 000 stops the interval counter; it keeps its value.
- R6: Clock-select codes 1 to 7 step the counter every 4, 16, 64, 256, 1024, 2048 and 4096 clocks, so with compare value C the refresh requests come every (C+1) x divider clocks, each one clock wide.
- R7: The match flag sets when the counter becomes equal to the compare value. After 0 is written to it, it keeps reading 1 until the next refresh request is issued, and it is 0 right after that request.
- R8: `irq_match` equals match flag AND match-irq enable.
- R9: No refresh request is issued while `rfsh_en`=0 or `rfsh_cbr`=0. An armed flag clear then stays pending, and the flag stays 1.
- R10: The overflow flag sets on the refresh request that brings the tally to LIM1 (limit select 1) or LIM0 (limit select 0). `irq_ovf` equals the overflow flag AND the overflow-irq enable. The flag clears by the same write-0-then-refresh rule as the match flag.
- R11: The counter (address 1) and the compare value (address 2) read zero-extended to 16 bits, and the counter reads 0 right after a refresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_addr | input | 2 | Register select: 0 control/status, 1 counter, 2 compare |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | Marks the access as a full 16-bit word |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 16 | Read data for the selected register |
| rfsh_en | input | 1 | Refresh enabled by the memory controller |
| rfsh_cbr | input | 1 | 1 for CBR refresh mode, 0 for self-refresh |
| refresh_req | output | 1 | One-cycle refresh request |
| irq_match | output | 1 | Compare-match interrupt |
| irq_ovf | output | 1 | Refresh-tally overflow interrupt |

## Verification
The bench builds the timer with refresh-tally limits of 16 and 8 in place of 1024 and 512, so that overflow and its clear can be reached within a few hundred refreshes. The 8-bit counter and the full set of clock-select codes are kept. With those limits, every clock-select code is swept against several compare values, including 0, and the request spacing is checked against (C+1) x divider. Every one of the 256 upper-byte values is tried as a write key.

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W = 8,
  parameter int LIM0 = 1024,
  parameter int LIM1 = 512,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rfsh_en,
  input  logic        rfsh_cbr,
  output logic        refresh_req,
  output logic        irq_match,
  output logic        irq_ovf
);
  localparam int PRE_W = 12;
  localparam int LIM_MAX = (LIM0 > LIM1) ? LIM0 : LIM1;
  localparam int RC_W = $clog2(LIM_MAX);
  localparam logic [RC_W-1:0] TOP0 = RC_W'(LIM0 - 1);
  localparam logic [RC_W-1:0] TOP1 = RC_W'(LIM1 - 1);

  logic [PRE_W-1:0] pre, mask;
  logic [CNT_W-1:0] cnt, cmp;
  logic [RC_W-1:0]  rc, rc_top;
  logic [2:0]       cks;
  logic             cmf, cmie, ovf, ovie, lmts;
  logic             cmf_arm, ovf_arm, match_q;
  logic             key_ok, wr_csr, wr_cnt, wr_cmp;
  logic             tick, match, do_rfsh;
  logic             cmf_set, cmf_clr, ovf_set, ovf_clr;

  assign key_ok = bus_wr && bus_word && (bus_wdata[15:8] == KEY);
  assign wr_csr = key_ok && (bus_addr == 2'd0);
  assign wr_cnt = key_ok && (bus_addr == 2'd1);
  assign wr_cmp = key_ok && (bus_addr == 2'd2);

  always_comb begin
    case (cks)
      3'd1: mask = PRE_W'(12'h003);
      3'd2: mask = PRE_W'(12'h00F);
      3'd3: mask = PRE_W'(12'h03F);
      3'd4: mask = PRE_W'(12'h0FF);
      3'd5: mask = PRE_W'(12'h3FF);
      3'd6: mask = PRE_W'(12'h7FF);
      3'd7: mask = PRE_W'(12'hFFF);
      default: mask = '0;
    endcase
  end

  assign tick    = (cks != 3'd0) && ((pre & mask) == mask);
  assign match   = (cnt == cmp);
  assign do_rfsh = tick && match && rfsh_en && rfsh_cbr;
  assign rc_top  = lmts ? TOP1 : TOP0;

  assign cmf_set = match && !match_q;
  assign cmf_clr = do_rfsh && cmf_arm && !cmf_set;
  assign ovf_set = do_rfsh && (rc >= rc_top);
  assign ovf_clr = do_rfsh && ovf_arm && !ovf_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= '0;
      match_q <= 1'b1;
      refresh_req <= 1'b0;
    end else begin
      match_q <= match;
      refresh_req <= do_rfsh;
      if (wr_cmp) cmp <= bus_wdata[CNT_W-1:0];
      if (wr_cnt)    cnt <= bus_wdata[CNT_W-1:0];
      else if (tick) cnt <= match ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmie <= 1'b0;
      cks  <= 3'd0;
      ovie <= 1'b0;
      lmts <= 1'b0;
    end else if (wr_csr) begin
      cmie <= bus_wdata[6];
      cks  <= bus_wdata[5:3];
      ovie <= bus_wdata[1];
      lmts <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmf <= 1'b0;
      cmf_arm <= 1'b0;
    end else begin
      if (cmf_set)      cmf <= 1'b1;
      else if (cmf_clr) cmf <= 1'b0;
      if (cmf_clr)                             cmf_arm <= 1'b0;
      else if (wr_csr && !bus_wdata[7] && cmf) cmf_arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc <= '0;
      ovf <= 1'b0;
      ovf_arm <= 1'b0;
    end else begin
      if (do_rfsh) rc <= (rc >= rc_top) ? '0 : rc + 1'b1;
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (ovf_clr)                             ovf_arm <= 1'b0;
      else if (wr_csr && !bus_wdata[2] && ovf) ovf_arm <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {8'h00, cmf, cmie, cks, ovf, ovie, lmts};
      2'd1:    bus_rdata = {{(16-CNT_W){1'b0}}, cnt};
      2'd2:    bus_rdata = {{(16-CNT_W){1'b0}}, cmp};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign irq_match = cmf && cmie;
  assign irq_ovf   = ovf && ovie;
endmodule

// File: rtl/refresh_interval_timer_chk.sv
module refresh_interval_timer_chk #(
  parameter int CNT_W = 8,
  parameter logic [7:0] KEY = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_word,
  input logic [15:0]      bus_wdata,
  input logic [15:0]      bus_rdata,
  input logic             rfsh_en,
  input logic             rfsh_cbr,
  input logic             refresh_req,
  input logic             cmf,
  input logic [2:0]       cks,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp
);
  logic cnt_written;
  assign cnt_written = bus_wr && bus_word && bus_wdata[15:8] == KEY && bus_addr == 2'd1;

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_wdata[15:8] != KEY || !bus_word)) |=> $stable(cmp));

  p_csr_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'h00));

  p_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cks == 3'd0 && !cnt_written) |=> $stable(cnt));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmf) |-> refresh_req);

  p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh_en && rfsh_cbr) |=> !refresh_req);

  p_cnt_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> (cnt == '0 || $past(cnt_written)));
endmodule

bind refresh_interval_timer refresh_interval_timer_chk #(.CNT_W(CNT_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rfsh_en(rfsh_en), .rfsh_cbr(rfsh_cbr),
  .refresh_req(refresh_req), .cmf(cmf), .cks(cks), .cnt(cnt), .cmp(cmp)
);

// File: tb/test_refresh_interval_timer.sv
module test_refresh_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int L0 = 16;
  localparam int L1 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic rfsh_en = 1'b0, rfsh_cbr = 1'b0;
  logic refresh_req, irq_match, irq_ovf;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_interval_timer #(.CNT_W(8), .LIM0(L0), .LIM1(L1)) i_refresh_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rfsh_en(rfsh_en), .rfsh_cbr(rfsh_cbr),
    .refresh_req(refresh_req), .irq_match(irq_match), .irq_ovf(irq_ovf));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_word = 1'b0; bus_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic word = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_word = word;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!refresh_req);
  endtask

  function automatic int divider(input int c);
    case (c)
      1: return 4; 2: return 16; 3: return 64; 4: return 256;
      5: return 1024; 6: return 2048; default: return 4096;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0] exp_cmp;
    int n, p;

    do_reset();
    @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d); chk("R1 reg after reset", d, 16'h0);
    end
    chk("R1 refresh_req", refresh_req, 0);
    chk("R1 irq_match", irq_match, 0);
    chk("R1 irq_ovf", irq_ovf, 0);

    exp_cmp = 8'h00;
    for (int k = 0; k < 256; k++) begin
      wr(2'd2, {8'(k), 8'(k) ^ 8'h3C});
      if (k == 8'hA5) exp_cmp = 8'(k) ^ 8'h3C;
      @(negedge clk); rd(2'd2, d); chk("R2 key sweep compare", d, {8'h00, exp_cmp});
    end
    wr(2'd2, 16'hA511, 1'b0);
    @(negedge clk); rd(2'd2, d); chk("R2 byte write ignored", d, {8'h00, exp_cmp});

    wr(2'd0, 16'hA5FF);
    @(negedge clk); rd(2'd0, d); chk("R3 R4 csr readback", d, 16'h007B);
    wr(2'd0, 16'h5A00);
    @(negedge clk); rd(2'd0, d); chk("R2 csr bad key", d, 16'h007B);
    wr(2'd0, 16'hA500);
    @(negedge clk); rd(2'd0, d); chk("R3 csr cleared", d, 16'h0000);

    wr(2'd1, 16'hA505);
    repeat (60) @(negedge clk);
    rd(2'd1, d); chk("R5 stopped counter", d, 16'h0005);

    rfsh_en = 1'b1; rfsh_cbr = 1'b1;
    for (int c = 1; c <= 7; c++) begin
      for (int j = 0; j < ((c <= 4) ? 4 : 2); j++) begin
        int cv;
        cv = (j == 3) ? 5 : j;
        wr(2'd2, 16'hA500 | 16'(cv));
        wr(2'd1, 16'hA500);
        wr(2'd0, 16'hA580 | 16'(c << 3));
        wait_req(n);
        wait_req(n); chk($sformatf("R6 period cks=%0d cmp=%0d", c, cv), n, (cv + 1) * divider(c));
        wait_req(n); chk($sformatf("R6 period cks=%0d cmp=%0d", c, cv), n, (cv + 1) * divider(c));
        @(negedge clk); chk("R6 pulse width", refresh_req, 0);
      end
    end

    do_reset();
    rfsh_en = 1'b1; rfsh_cbr = 1'b1;
    wr(2'd2, 16'hA503);
    wr(2'd0, 16'hA5C8);
    wait_req(n);
    rd(2'd1, d); chk("R11 counter zero after request", d, 16'h0000);
    rd(2'd0, d); chk("R7 flag set", d[7], 1);
    chk("R8 irq with enable", irq_match, 1);
    wr(2'd0, 16'hA548);
    @(negedge clk); rd(2'd0, d); chk("R7 flag holds until refresh", d[7], 1);
    wait_req(n);
    rd(2'd0, d); chk("R7 flag cleared by refresh", d[7], 0);
    chk("R8 irq follows flag", irq_match, 0);
    wr(2'd0, 16'hA5C8);
    @(negedge clk); rd(2'd0, d); chk("R4 write 1 does not set flag", d[7], 0);
    wait_req(n);
    rd(2'd0, d); chk("R7 flag set again", d[7], 1);
    wr(2'd0, 16'hA588);
    @(negedge clk); chk("R8 irq disabled", irq_match, 0);

    rfsh_cbr = 1'b0;
    wr(2'd0, 16'hA508);
    p = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (refresh_req) p++;
    end
    chk("R9 no request in self-refresh", p, 0);
    rd(2'd0, d); chk("R9 flag held while gated", d[7], 1);
    rfsh_cbr = 1'b1;
    wait_req(n);
    rd(2'd0, d); chk("R9 pending clear applied", d[7], 0);
    rfsh_en = 1'b0;
    p = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (refresh_req) p++;
    end
    chk("R9 no request when disabled", p, 0);

    do_reset();
    rfsh_en = 1'b1; rfsh_cbr = 1'b1;
    wr(2'd2, 16'hA501);
    wr(2'd0, 16'hA58B);
    for (int i = 1; i <= L1; i++) begin
      wait_req(n);
      rd(2'd0, d);
      chk($sformatf("R10 ovf limit1 refresh %0d", i), d[2], (i == L1));
      chk($sformatf("R10 irq_ovf refresh %0d", i), irq_ovf, (i == L1));
    end
    wr(2'd0, 16'hA58F);
    wait_req(n);
    rd(2'd0, d); chk("R4 write 1 keeps ovf", d[2], 1);
    wr(2'd0, 16'hA58B);
    @(negedge clk); rd(2'd0, d); chk("R10 ovf holds until refresh", d[2], 1);
    wait_req(n);
    rd(2'd0, d); chk("R10 ovf cleared by refresh", d[2], 0);
    chk("R10 irq_ovf cleared", irq_ovf, 0);

    do_reset();
    rfsh_en = 1'b1; rfsh_cbr = 1'b1;
    wr(2'd2, 16'hA501);
    wr(2'd0, 16'hA588);
    for (int i = 1; i <= L0; i++) begin
      wait_req(n);
      rd(2'd0, d);
      chk($sformatf("R10 ovf limit0 refresh %0d", i), d[2], (i == L0));
    end
    chk("R10 irq_ovf masked", irq_ovf, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule